// File: doc/BRIEF.md
# Extended Relative Branch Unit

This unit executes three control-transfer instructions of a byte-serial controller core. These are a far relative jump (opcode 0xE6), a far relative call (opcode 0xF1) and interrupt enable (opcode 0xFB). Instruction bytes come in one per accepted fetch handshake. The unit holds the program counter and the stack pointer, issues the return-address store for a call on a single-word write port, and holds the interrupt-enable bit. From these it derives a qualifier that tells the interrupt controller when an interrupt may be taken.

A far branch is four bytes long: the opcode, then a 24-bit two's-complement displacement sent low byte first, middle byte next and top byte last. The displacement is added to the address that follows the instruction. Two address spaces can be selected, 24-bit and 20-bit. Any opcode the unit does not own is treated as a one-byte instruction: the counter steps past it and it counts as a completed instruction.

Top module: `xbr_unit`

## Requirements
- R1: While rst_n is low at a clock edge, pc_q is set to RESET_PC, sp_q to RESET_SP, int_enable to 0, busy to 0, wr_valid to 0 and int_allowed to 0.
- R2: A byte is taken on each rising edge where fetch_valid and fetch_ready are both high. fetch_ready is low only while a call's store is pending. Each byte taken of a far branch's first three bytes, and of any other opcode except a refused one (R7), advances pc_q by one.
- R3: When the top displacement byte of opcode 0xE6 is taken, pc_q becomes the address after the instruction plus the sign-extended displacement {top,mid,low} in the same edge. insn_done pulses for one cycle. sp_q is unchanged and no write is issued.
- R4: When the top displacement byte of opcode 0xF1 is taken, sp_q drops by 4 and pc_q holds the return address (the address after the instruction). wr_valid rises with wr_addr equal to the new sp_q. wr_data carries the return address in bits 23:0 with bits 31:24 zero, lowest address byte in bits 7:0.
- R5: The store request holds wr_addr and wr_data unchanged until wr_ready is sampled high. On that edge pc_q becomes the return address plus the sign-extended displacement, busy falls and insn_done pulses.
- R6: With addr20 low, all address arithmetic wraps modulo 2^24. With addr20 high, pc_q, the target, the return address and sp_q are masked to their low 20 bits.
- R7: With ext_mode low, opcode 0xE6 or 0xF1 is taken but refused. illegal_op pulses for one cycle; pc_q and sp_q stay unchanged, insn_done stays low and no write is issued.
- R8: Opcode 0xFB sets int_enable, advances pc_q by one and pulses insn_done.
- R9: int_allowed equals int_enable while no interrupt-enable shadow is open and busy is low. The shadow opens when 0xFB completes. It closes only when a later instruction other than 0xFB completes; a refused opcode does not close it.
- R10: Any opcode other than 0xE6, 0xF1 and 0xFB completes in one byte. It pulses insn_done and changes nothing besides pc_q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_mode | input | 1 | Far addressing permitted |
| addr20 | input | 1 | 1 selects 20-bit address space, 0 selects 24-bit |
| fetch_valid | input | 1 | Instruction byte present |
| fetch_byte | input | 8 | Instruction byte |
| fetch_ready | output | 1 | Unit can take a byte |
| wr_valid | output | 1 | Return-address store request |
| wr_addr | output | 24 | Store address (new stack pointer) |
| wr_data | output | 32 | Return address, zero-filled top byte |
| wr_ready | input | 1 | Store accepted |
| busy | output | 1 | Multi-byte instruction in progress |
| insn_done | output | 1 | One-cycle pulse at instruction completion |
| illegal_op | output | 1 | One-cycle pulse on a refused far opcode |
| pc_q | output | 24 | Program counter |
| sp_q | output | 24 | Stack pointer |
| int_enable | output | 1 | Interrupt-enable status bit |
| int_allowed | output | 1 | Interrupt may be taken now |

## Verification
The completion of the instruction after an interrupt enable happens on the same edge as that instruction's program-counter load. For a call, that load is itself the edge where the stalled store is accepted. The bench issues 0xFB and follows it with a call whose store it holds off for several cycles. A cycle-level reference model must show int_allowed low through every stall cycle and high on the cycle after the store is accepted, together with the new pc_q. Chained enables and refused opcodes placed inside the shadow check that only a real completion closes it.

// File: rtl/xbr_pkg.sv
// Shared encodings for the far-branch unit.
// Assumes byte-wide opcodes and a three-byte displacement field.
package xbr_pkg;
    localparam logic [7:0] OPC_FAR_JUMP = 8'hE6;
    localparam logic [7:0] OPC_FAR_CALL = 8'hF1;
    localparam logic [7:0] OPC_INT_ON   = 8'hFB;
    localparam int DISP_BYTES = 3;

    typedef enum logic [2:0] {
        ST_OPC  = 3'd0,
        ST_LOW  = 3'd1,
        ST_MID  = 3'd2,
        ST_TOP  = 3'd3,
        ST_PUSH = 3'd4
    } xbr_state_e;
endpackage

// File: rtl/xbr_opc_decode.sv
// Classifies an opcode byte for the far-branch unit.
// Assumes the byte is the first byte of an instruction.
module xbr_opc_decode
    import xbr_pkg::*;
(
    input  logic [7:0] opc,
    output logic       is_jump,
    output logic       is_call,
    output logic       is_int_on
);
    // Opcode compare against the three owned encodings.
    always_comb begin
        is_jump   = (opc == OPC_FAR_JUMP);
        is_call   = (opc == OPC_FAR_CALL);
        is_int_on = (opc == OPC_INT_ON);
    end
endmodule

// File: rtl/xbr_wrap_add.sv
// Address adder that wraps at W bits, or at NW bits when narrow is set.
// Assumes 0 < NW <= W.
module xbr_wrap_add #(
    parameter int W  = 24,
    parameter int NW = 20
) (
    input  logic [W-1:0] base,
    input  logic [W-1:0] offs,
    input  logic         narrow,
    output logic [W-1:0] sum
);
    localparam logic [W-1:0] NARROW_MASK =
        (NW >= W) ? {W{1'b1}} : ((W'(1) << NW) - W'(1));

    logic [W-1:0] raw;

    // Full-width sum, then the mask selected by the address mode.
    always_comb begin
        raw = base + offs;
        sum = narrow ? (raw & NARROW_MASK) : raw;
    end
endmodule

// File: rtl/xbr_ie_shadow.sv
// Holds the interrupt-enable bit and the one-instruction shadow behind it.
// Assumes ei_commit and other_retire are single-cycle strobes.
module xbr_ie_shadow (
    input  logic clk,
    input  logic rst_n,
    input  logic ei_commit,
    input  logic other_retire,
    input  logic unit_idle,
    output logic int_enable,
    output logic int_allowed
);
    logic shadow_q;

    // Enable and shadow state: set by enable, shadow closed by next completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_enable <= 1'b0;
            shadow_q   <= 1'b0;
        end else if (ei_commit) begin
            int_enable <= 1'b1;
            shadow_q   <= 1'b1;
        end else if (other_retire) begin
            shadow_q   <= 1'b0;
        end
    end

    // Qualifier for the interrupt controller.
    always_comb int_allowed = int_enable && !shadow_q && unit_idle;

    assert_shadow_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        shadow_q |-> int_enable);
    assert_shadow_closes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (other_retire && !ei_commit) |=> !shadow_q);
    assert_enable_opens_shadow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ei_commit |=> (int_enable && !int_allowed));
endmodule

// File: rtl/xbr_unit.sv
// Far relative jump / call / interrupt-enable executor.
// Takes instruction bytes one per handshake, keeps PC and SP, issues the
// call's return-address store and qualifies interrupt acceptance.
// Assumes WORD_W > ADDR_W >= 8*DISP_BYTES and mode inputs steady per instruction.
module xbr_unit
    import xbr_pkg::*;
#(
    parameter int              ADDR_W   = 24,
    parameter int              NARROW_W = 20,
    parameter int              WORD_W   = 32,
    parameter logic [ADDR_W-1:0] RESET_PC = 24'h002080,
    parameter logic [ADDR_W-1:0] RESET_SP = 24'h000200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_mode,
    input  logic              addr20,
    input  logic              fetch_valid,
    input  logic [7:0]        fetch_byte,
    output logic              fetch_ready,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    input  logic              wr_ready,
    output logic              busy,
    output logic              insn_done,
    output logic              illegal_op,
    output logic [ADDR_W-1:0] pc_q,
    output logic [ADDR_W-1:0] sp_q,
    output logic              int_enable,
    output logic              int_allowed
);
    localparam int DISP_W = 8 * DISP_BYTES;
    localparam logic [ADDR_W-1:0] STEP_ONE   = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] STACK_DROP = ~ADDR_W'(3);

    xbr_state_e        state_q;
    logic [7:0]        disp_low_q, disp_mid_q;
    logic [DISP_W-1:0] disp_q;
    logic              call_q;
    logic              fire;
    logic              dec_jump, dec_call, dec_int_on, dec_far;
    logic signed [DISP_W-1:0] disp_now;
    logic [ADDR_W-1:0] disp_ext, tgt_base;
    logic [ADDR_W-1:0] pc_inc, pc_tgt, sp_dec;
    logic              ei_commit, other_retire;

    xbr_opc_decode u_dec (
        .opc       (fetch_byte),
        .is_jump   (dec_jump),
        .is_call   (dec_call),
        .is_int_on (dec_int_on)
    );

    // Byte acceptance and displacement selection for the target adder.
    always_comb begin
        fetch_ready = (state_q != ST_PUSH);
        fire        = fetch_valid && fetch_ready;
        dec_far     = dec_jump || dec_call;
        disp_now    = (state_q == ST_TOP) ? {fetch_byte, disp_mid_q, disp_low_q}
                                          : disp_q;
        disp_ext    = ADDR_W'(disp_now);
        tgt_base    = (state_q == ST_TOP) ? pc_inc : pc_q;
    end

    xbr_wrap_add #(.W(ADDR_W), .NW(NARROW_W)) u_pc_step (
        .base (pc_q), .offs (STEP_ONE), .narrow (addr20), .sum (pc_inc)
    );
    xbr_wrap_add #(.W(ADDR_W), .NW(NARROW_W)) u_target (
        .base (tgt_base), .offs (disp_ext), .narrow (addr20), .sum (pc_tgt)
    );
    xbr_wrap_add #(.W(ADDR_W), .NW(NARROW_W)) u_stack (
        .base (sp_q), .offs (STACK_DROP), .narrow (addr20), .sum (sp_dec)
    );

    // Completion strobes feeding the interrupt-enable shadow.
    always_comb begin
        ei_commit    = fire && (state_q == ST_OPC) && dec_int_on;
        other_retire = (fire && (state_q == ST_OPC) && !dec_far && !dec_int_on)
                    || (fire && (state_q == ST_TOP) && !call_q)
                    || ((state_q == ST_PUSH) && wr_ready);
    end

    xbr_ie_shadow u_ie (
        .clk          (clk),
        .rst_n        (rst_n),
        .ei_commit    (ei_commit),
        .other_retire (other_retire),
        .unit_idle    (!busy),
        .int_enable   (int_enable),
        .int_allowed  (int_allowed)
    );

    // Instruction sequencer: byte collection, PC/SP update, store wait.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_OPC;
            pc_q       <= RESET_PC;
            sp_q       <= RESET_SP;
            disp_low_q <= '0;
            disp_mid_q <= '0;
            disp_q     <= '0;
            call_q     <= 1'b0;
            insn_done  <= 1'b0;
            illegal_op <= 1'b0;
        end else begin
            insn_done  <= 1'b0;
            illegal_op <= 1'b0;
            case (state_q)
                ST_OPC: if (fire) begin
                    if (dec_far && !ext_mode) begin
                        illegal_op <= 1'b1;
                    end else if (dec_far) begin
                        call_q  <= dec_call;
                        pc_q    <= pc_inc;
                        state_q <= ST_LOW;
                    end else begin
                        pc_q      <= pc_inc;
                        insn_done <= 1'b1;
                    end
                end
                ST_LOW: if (fire) begin
                    disp_low_q <= fetch_byte;
                    pc_q       <= pc_inc;
                    state_q    <= ST_MID;
                end
                ST_MID: if (fire) begin
                    disp_mid_q <= fetch_byte;
                    pc_q       <= pc_inc;
                    state_q    <= ST_TOP;
                end
                ST_TOP: if (fire) begin
                    if (call_q) begin
                        disp_q  <= {fetch_byte, disp_mid_q, disp_low_q};
                        pc_q    <= pc_inc;
                        sp_q    <= sp_dec;
                        state_q <= ST_PUSH;
                    end else begin
                        pc_q      <= pc_tgt;
                        insn_done <= 1'b1;
                        state_q   <= ST_OPC;
                    end
                end
                ST_PUSH: if (wr_ready) begin
                    pc_q      <= pc_tgt;
                    insn_done <= 1'b1;
                    state_q   <= ST_OPC;
                end
                default: state_q <= ST_OPC;
            endcase
        end
    end

    // Store port and status outputs.
    always_comb begin
        busy     = (state_q != ST_OPC);
        wr_valid = (state_q == ST_PUSH);
        wr_addr  = sp_q;
        wr_data  = WORD_W'(pc_q);
    end

    assert_store_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));
    assert_store_top_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> ((wr_data >> ADDR_W) == '0));
    assert_refused_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_op |-> (pc_q == $past(pc_q) && sp_q == $past(sp_q) && !insn_done && !wr_valid));
    assert_done_keeps_sp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_done && !$past(wr_valid)) |-> (sp_q == $past(sp_q)));
    assert_stall_blocks_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !fetch_ready);
    assert_narrow_pc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (addr20 && $past(addr20) && $changed(pc_q)) |-> ((pc_q >> NARROW_W) == '0));
endmodule

// File: tb/xbr_unit_tb_top.sv
module xbr_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_mode = 1'b1;
    logic        addr20 = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [7:0]  fetch_byte = 8'h00;
    logic        fetch_ready;
    logic        wr_valid;
    logic [23:0] wr_addr;
    logic [31:0] wr_data;
    logic        wr_ready = 1'b0;
    logic        busy, insn_done, illegal_op, int_enable, int_allowed;
    logic [23:0] pc_q, sp_q;

    always #4 clk = ~clk;

    xbr_unit dut_i (
        .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .addr20(addr20),
        .fetch_valid(fetch_valid), .fetch_byte(fetch_byte), .fetch_ready(fetch_ready),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
        .busy(busy), .insn_done(insn_done), .illegal_op(illegal_op),
        .pc_q(pc_q), .sp_q(sp_q), .int_enable(int_enable), .int_allowed(int_allowed)
    );

    int total = 0;
    int failed = 0;
    int cycles = 0;
    int m_pc, m_sp;
    bit m_ie, m_sh, m_busy;

    function automatic int wrap(input int x);
        return addr20 ? (x & 32'h000FFFFF) : (x & 32'h00FFFFFF);
    endfunction

    function automatic int sx(input int d);
        int v;
        v = d & 32'h00FFFFFF;
        return (v & 32'h00800000) != 0 ? v - 32'h01000000 : v;
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // Compare every visible output against the model.
    task automatic cmp(input string rq, input bit e_done, input bit e_ill, input bit e_wr);
        bit e_ok;
        e_ok = m_ie && !m_sh && !m_busy;
        chk(int'(pc_q) == m_pc, rq, "pc", int'(pc_q), m_pc);
        chk(int'(sp_q) == m_sp, rq, "sp", int'(sp_q), m_sp);
        chk(int_enable == m_ie, rq, "int_enable", int'(int_enable), int'(m_ie));
        chk(int_allowed == e_ok, rq, "int_allowed", int'(int_allowed), int'(e_ok));
        chk(busy == m_busy, rq, "busy", int'(busy), int'(m_busy));
        chk(insn_done == e_done, rq, "insn_done", int'(insn_done), int'(e_done));
        chk(illegal_op == e_ill, rq, "illegal_op", int'(illegal_op), int'(e_ill));
        chk(wr_valid == e_wr, rq, "wr_valid", int'(wr_valid), int'(e_wr));
        chk(fetch_ready == !e_wr, rq, "fetch_ready", int'(fetch_ready), int'(!e_wr));
    endtask

    task automatic edge_wait();
        @(posedge clk);
        #2;
    endtask

    task automatic push_byte(input logic [7:0] b);
        @(negedge clk);
        fetch_valid = 1'b1;
        fetch_byte  = b;
        edge_wait();
        fetch_valid = 1'b0;
    endtask

    task automatic idle(input int n, input string rq);
        for (int k = 0; k < n; k++) begin
            edge_wait();
            cmp(rq, 0, 0, 0);
        end
    endtask

    task automatic do_jump(input int disp, input string rq);
        push_byte(8'hE6); m_pc = wrap(m_pc + 1); m_busy = 1; cmp(rq, 0, 0, 0);
        push_byte(disp[7:0]);   m_pc = wrap(m_pc + 1); cmp(rq, 0, 0, 0);
        push_byte(disp[15:8]);  m_pc = wrap(m_pc + 1); cmp(rq, 0, 0, 0);
        push_byte(disp[23:16]);
        m_pc = wrap(m_pc + 1 + sx(disp)); m_busy = 0; m_sh = 0;
        cmp(rq, 1, 0, 0);
    endtask

    task automatic do_call(input int disp, input int stall, input string rq);
        int ret;
        push_byte(8'hF1); m_pc = wrap(m_pc + 1); m_busy = 1; cmp(rq, 0, 0, 0);
        push_byte(disp[7:0]);   m_pc = wrap(m_pc + 1); cmp(rq, 0, 0, 0);
        push_byte(disp[15:8]);  m_pc = wrap(m_pc + 1); cmp(rq, 0, 0, 0);
        push_byte(disp[23:16]);
        ret  = wrap(m_pc + 1);
        m_pc = ret;
        m_sp = wrap(m_sp - 4);
        cmp(rq, 0, 0, 1);
        chk(int'(wr_addr) == m_sp, "R4", "wr_addr", int'(wr_addr), m_sp);
        chk(int'(wr_data) == ret, "R4", "wr_data", int'(wr_data), ret);
        for (int k = 0; k < stall; k++) begin
            edge_wait();
            cmp("R5", 0, 0, 1);
            chk(int'(wr_addr) == m_sp, "R5", "held wr_addr", int'(wr_addr), m_sp);
            chk(int'(wr_data) == ret, "R5", "held wr_data", int'(wr_data), ret);
        end
        @(negedge clk);
        wr_ready = 1'b1;
        edge_wait();
        wr_ready = 1'b0;
        m_pc = wrap(ret + sx(disp)); m_busy = 0; m_sh = 0;
        cmp(rq, 1, 0, 0);
    endtask

    task automatic do_ei(input string rq);
        push_byte(8'hFB);
        m_pc = wrap(m_pc + 1); m_ie = 1; m_sh = 1;
        cmp(rq, 1, 0, 0);
    endtask

    task automatic do_other(input logic [7:0] b, input string rq);
        push_byte(b);
        m_pc = wrap(m_pc + 1); m_sh = 0;
        cmp(rq, 1, 0, 0);
    endtask

    task automatic do_refused(input logic [7:0] b, input string rq);
        ext_mode = 1'b0;
        push_byte(b);
        cmp(rq, 0, 1, 0);
        ext_mode = 1'b1;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    endtask

    // Watchdog: a hung run is counted as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            total++;
            failed++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 150000);
            finish_run();
        end
    end

    initial begin
        m_pc = 32'h002080; m_sp = 32'h000200; m_ie = 0; m_sh = 0; m_busy = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        cmp("R1", 0, 0, 0);
        idle(1, "R1");

        do_jump(32'h000100, "R3");                 // forward, R2 byte stepping
        do_jump(32'hFFFFB0, "R3");                 // backward
        do_other(8'h00, "R10");
        do_other(8'h7A, "R10");
        do_call(32'h001000, 0, "R4");
        do_call(32'hFFFD00, 3, "R5");
        do_jump(32'h7FFFFF, "R6");                 // 24-bit wrap
        do_jump(32'h800000, "R6");

        do_ei("R8");
        idle(2, "R9");
        do_jump(32'h000010, "R9");
        idle(1, "R9");

        do_ei("R9");
        do_call(32'h000040, 2, "R9");               // shadow release at store accept
        idle(1, "R9");

        do_ei("R9");
        do_ei("R9");
        idle(1, "R9");
        do_other(8'h12, "R9");

        do_ei("R9");
        do_refused(8'hE6, "R7");
        do_refused(8'hF1, "R7");
        idle(1, "R7");
        do_other(8'h34, "R9");

        @(negedge clk);
        addr20 = 1'b1;
        do_other(8'h01, "R6");                     // PC masked to 20 bits
        do_jump(32'h0FFFF0, "R6");
        do_jump(32'h900020, "R6");                 // beyond narrow range wraps
        m_sp = wrap(m_sp);
        do_call(32'h0F0000, 1, "R6");
        idle(2, "R6");

        finish_run();
    end
endmodule